// File: doc/BRIEF.md
# Stack Processor Fetch-Execute Sequencer

This block is the instruction sequencer of a 32-bit two-stack processor. Compiled code for this processor is a plain list of native instructions and subroutine calls. No software interpreter walks it. The sequencer fetches each word from a single synchronous memory port and classifies it by its top three bits. It then issues the strobes for the parameter stack, the return stack and the ALU, and steers the next fetch address.

Calls and returns are handled inside the fetch-execute loop itself. A call saves the address of the following word on the return stack and fetches its target in the same cycle. A return fetches from the saved address and pops it. ALU/stack operations, calls, returns and conditional branches each take one cycle. Memory loads and stores take two cycles. The memory returns read data one cycle after the address is presented and holds its output while no read is issued.

The stacks themselves live outside the block. The sequencer sees only their top entries (`pTop`, `rTop`) and drives their push and pop strobes. A stack pop takes effect at the clock edge ending the cycle that asserts it.

Top module: `stack_seq`

## Requirements
- R1: While `rstN` is low, no strobe is asserted (`memRd`, `memWr`, `pPush`, `pPop`, `rPush`, `rPop`, `aluEn` all 0). In the first cycle after release, the block reads address 0 with `memRd` high.
- R2: The instruction class is bits 31:29 of the word. Class 0, 6 and 7 is ALU/stack, 1 is load, 2 is store, 3 is call, 4 is return and 5 is branch-if-zero. For classes 3 and 5, the target is bits 28:0 zero-extended to 32 bits. An ALU/stack word takes one cycle: `aluEn` is high, `aluWord` equals bits 28:0, and the next sequential address is fetched.
- R3: A load takes two cycles. In the first, `memAddr` equals `pTop`, `memRd` is high and `pPop` is high. In the second, `pPush` is high with `pPushData` equal to `memRdata`, and the next sequential address is fetched.
- R4: A store takes two cycles. In the first, the next sequential address is fetched and `pPop` is high. In the second, `memWr` is high at the address that `pTop` held in the first cycle, `memWdata` equals the current `pTop`, `pPop` is high and `memRd` is low. The word fetched in the first cycle executes in the cycle after the write.
- R5: A call takes one cycle. `rPush` is high with `rPushData` equal to the call's own address plus one, and the target is fetched.
- R6: A return takes one cycle. `rPop` is high and `rTop` is fetched. Returns after nested calls resume in reverse order of the calls.
- R7: A branch-if-zero takes one cycle with `pPop` high. It fetches the target when `pTop` is zero and the next sequential address otherwise.
- R8: `memRd` and `memWr` are never high together, and `rPush` and `rPop` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | 32 | Memory word address |
| memRd | output | 1 | Memory read strobe (fetch or load) |
| memWr | output | 1 | Memory write strobe |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Read data, valid the cycle after a read |
| pTop | input | 32 | Top entry of the parameter stack |
| pPush | output | 1 | Parameter stack push |
| pPop | output | 1 | Parameter stack pop |
| pPushData | output | 32 | Value pushed on the parameter stack |
| rTop | input | 32 | Top entry of the return stack |
| rPush | output | 1 | Return stack push |
| rPop | output | 1 | Return stack pop |
| rPushData | output | 32 | Return address pushed |
| aluEn | output | 1 | ALU/stack operation strobe |
| aluWord | output | 29 | Operation field of the executing word |

## Verification
A store's write cycle coincides with the capture of the next word, which was fetched early in the store's first cycle. That word then has to run from the holding register one cycle later. The bench provokes this with a directed program that places stores directly before returns and calls. Random programs add stores followed by every other class. Each cycle, the bench checks the write address and data, and checks that the next fetch address follows from the held word rather than from the stale memory output.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU   = 3'd0,
    CL_LOAD  = 3'd1,
    CL_STORE = 3'd2,
    CL_CALL  = 3'd3,
    CL_RET   = 3'd4,
    CL_BRZ   = 3'd5,
    CL_ALU6  = 3'd6,
    CL_ALU7  = 3'd7
  } instClassT;

  typedef enum logic [1:0] {
    PH_BOOT   = 2'd0,
    PH_EXEC   = 2'd1,
    PH_LOAD2  = 2'd2,
    PH_STORE2 = 2'd3
  } phaseT;

  typedef enum logic [2:0] {
    AS_ZERO   = 3'd0,
    AS_PC     = 3'd1,
    AS_TARGET = 3'd2,
    AS_RTOP   = 3'd3,
    AS_PTOP   = 3'd4,
    AS_STADDR = 3'd5
  } addrSelT;

  typedef struct packed {
    addrSelT addrSel;
    logic    fetch;
    logic    dataRd;
    logic    dataWr;
    logic    captureHold;
    logic    useHold;
    logic    latchStAddr;
    logic    pPush;
    logic    pPop;
    logic    rPush;
    logic    rPop;
    logic    aluEn;
  } ctrlT;

endpackage

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlT                      ctrl,
  input  logic [ADDR_W-1:0]         memRdata,
  input  logic [ADDR_W-1:0]         pTop,
  input  logic [ADDR_W-1:0]         rTop,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [ADDR_W-1:0]         memWdata,
  output logic [ADDR_W-1:0]         pPushData,
  output logic [ADDR_W-1:0]         rPushData,
  output logic [CLS_W-1:0]          instClass,
  output logic                      pTopZero,
  output logic [ADDR_W-CLS_W-1:0]   aluWord
);

  localparam int TGT_W = ADDR_W - CLS_W;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] stAddr;
  logic [ADDR_W-1:0] holdWord;
  logic [ADDR_W-1:0] instWord;
  logic [ADDR_W-1:0] target;

  assign instWord = ctrl.useHold ? holdWord : memRdata;
  assign target   = {{CLS_W{1'b0}}, instWord[TGT_W-1:0]};

  always_comb begin
    unique case (ctrl.addrSel)
      AS_PC:     memAddr = pc;
      AS_TARGET: memAddr = target;
      AS_RTOP:   memAddr = rTop;
      AS_PTOP:   memAddr = pTop;
      AS_STADDR: memAddr = stAddr;
      default:   memAddr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= '0;
      stAddr   <= '0;
      holdWord <= '0;
    end else begin
      if (ctrl.fetch)       pc       <= memAddr + ADDR_W'(1);
      if (ctrl.latchStAddr) stAddr   <= pTop;
      if (ctrl.captureHold) holdWord <= memRdata;
    end
  end

  assign memWdata  = pTop;
  assign pPushData = memRdata;
  assign rPushData = pc;
  assign instClass = instWord[ADDR_W-1 -: CLS_W];
  assign pTopZero  = (pTop == '0);
  assign aluWord   = instWord[TGT_W-1:0];

endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CLS_W-1:0] instClass,
  input  logic             pTopZero,
  output ctrlT             ctrl
);

  phaseT phase, phaseNext;
  logic  holdValid, holdValidNext;
  ctrlT  ctrlRaw;

  always_comb begin
    ctrlRaw         = '0;
    ctrlRaw.addrSel = AS_PC;
    ctrlRaw.useHold = holdValid;
    phaseNext       = phase;
    holdValidNext   = 1'b0;
    unique case (phase)
      PH_BOOT: begin
        ctrlRaw.addrSel = AS_ZERO;
        ctrlRaw.fetch   = 1'b1;
        phaseNext       = PH_EXEC;
      end
      PH_EXEC: begin
        unique case (instClassT'(instClass))
          CL_LOAD: begin
            ctrlRaw.addrSel = AS_PTOP;
            ctrlRaw.dataRd  = 1'b1;
            ctrlRaw.pPop    = 1'b1;
            phaseNext       = PH_LOAD2;
          end
          CL_STORE: begin
            ctrlRaw.fetch       = 1'b1;
            ctrlRaw.latchStAddr = 1'b1;
            ctrlRaw.pPop        = 1'b1;
            phaseNext           = PH_STORE2;
          end
          CL_CALL: begin
            ctrlRaw.addrSel = AS_TARGET;
            ctrlRaw.fetch   = 1'b1;
            ctrlRaw.rPush   = 1'b1;
          end
          CL_RET: begin
            ctrlRaw.addrSel = AS_RTOP;
            ctrlRaw.fetch   = 1'b1;
            ctrlRaw.rPop    = 1'b1;
          end
          CL_BRZ: begin
            ctrlRaw.addrSel = pTopZero ? AS_TARGET : AS_PC;
            ctrlRaw.fetch   = 1'b1;
            ctrlRaw.pPop    = 1'b1;
          end
          default: begin
            ctrlRaw.fetch = 1'b1;
            ctrlRaw.aluEn = 1'b1;
          end
        endcase
      end
      PH_LOAD2: begin
        ctrlRaw.fetch = 1'b1;
        ctrlRaw.pPush = 1'b1;
        phaseNext     = PH_EXEC;
      end
      PH_STORE2: begin
        ctrlRaw.addrSel     = AS_STADDR;
        ctrlRaw.dataWr      = 1'b1;
        ctrlRaw.pPop        = 1'b1;
        ctrlRaw.captureHold = 1'b1;
        holdValidNext       = 1'b1;
        phaseNext           = PH_EXEC;
      end
      default: phaseNext = PH_BOOT;
    endcase
  end

  always_comb begin
    ctrl = ctrlRaw;
    if (!rstN) begin
      ctrl         = '0;
      ctrl.addrSel = AS_ZERO;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_BOOT;
      holdValid <= 1'b0;
    end else begin
      phase     <= phaseNext;
      holdValid <= holdValidNext;
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memRd,
  output logic                    memWr,
  output logic [ADDR_W-1:0]       memWdata,
  input  logic [ADDR_W-1:0]       memRdata,
  input  logic [ADDR_W-1:0]       pTop,
  output logic                    pPush,
  output logic                    pPop,
  output logic [ADDR_W-1:0]       pPushData,
  input  logic [ADDR_W-1:0]       rTop,
  output logic                    rPush,
  output logic                    rPop,
  output logic [ADDR_W-1:0]       rPushData,
  output logic                    aluEn,
  output logic [ADDR_W-CLS_W-1:0] aluWord
);

  ctrlT             ctrl;
  logic [CLS_W-1:0] instClass;
  logic             pTopZero;

  stack_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instClass (instClass),
    .pTopZero  (pTopZero),
    .ctrl      (ctrl)
  );

  stack_seq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .memRdata  (memRdata),
    .pTop      (pTop),
    .rTop      (rTop),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .pPushData (pPushData),
    .rPushData (rPushData),
    .instClass (instClass),
    .pTopZero  (pTopZero),
    .aluWord   (aluWord)
  );

  assign memRd = ctrl.fetch | ctrl.dataRd;
  assign memWr = ctrl.dataWr;
  assign pPush = ctrl.pPush;
  assign pPop  = ctrl.pPop;
  assign rPush = ctrl.rPush;
  assign rPop  = ctrl.rPop;
  assign aluEn = ctrl.aluEn;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic              memWr,
  input logic              pPush,
  input logic              pPop,
  input logic [ADDR_W-1:0] rTop,
  input logic              rPush,
  input logic              rPop,
  input logic              aluEn
);

  p_boot_fetch_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (memRd && memAddr == '0 && !memWr));

  p_alu_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    aluEn |-> (memRd && !memWr && !pPush));

  p_load_push_r3: assert property (@(posedge clk) disable iff (!rstN)
    pPush |-> ($past(memRd) && $past(pPop) && memRd && !memWr));

  p_store_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> ($past(memRd) && $past(pPop) && pPop && !$past(memWr)));

  p_call_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    rPush |-> (memRd && !pPush && !pPop && !aluEn));

  p_ret_fetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    rPop |-> (memRd && memAddr == rTop));

  p_port_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr) && !(rPush && rPop));

endmodule

bind stack_seq stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memAddr (memAddr),
  .memRd   (memRd),
  .memWr   (memWr),
  .pPush   (pPush),
  .pPop    (pPop),
  .rTop    (rTop),
  .rPush   (rPush),
  .rPop    (rPop),
  .aluEn   (aluEn)
);

// File: tb/stack_seq_bench.sv
module stack_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_DEPTH  = 64;
  localparam int RUN_CYCLES = 1500;
  localparam int PROGRAMS   = 4;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] memAddr, memWdata, pPushData, rPushData;
  logic        memRd, memWr, pPush, pPop, rPush, rPop, aluEn;
  logic [28:0] aluWord;
  logic [31:0] memRdata = '0;
  logic [31:0] rdNext = '0;
  logic [31:0] pTop = '0;
  logic [31:0] rTop = '0;

  logic [31:0] mem [MEM_DEPTH];

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int          mPhase;
  logic [31:0] mPc, mSt, mHold;
  bit          mUse;

  stack_seq u_stack_seq (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memRdata(memRdata), .pTop(pTop), .pPush(pPush),
    .pPop(pPop), .pPushData(pPushData), .rTop(rTop), .rPush(rPush),
    .rPop(rPop), .rPushData(rPushData), .aluEn(aluEn), .aluWord(aluWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) memRdata <= rdNext;

  function automatic logic [31:0] makeWord(int cls, int tgt);
    return {3'(cls), 29'(tgt)};
  endfunction

  function automatic logic [31:0] randWord();
    return makeWord(int'($urandom % 8), int'($urandom % MEM_DEPTH));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] strobes();
    return {25'd0, memRd, memWr, pPush, pPop, rPush, rPop, aluEn};
  endfunction

  task automatic evalCycle();
    logic [31:0] iw, tgt, eAddr, eStb;
    bit eRd, eWr, ePu, ePo, eRu, eRo, eAl;
    string tag;
    pTop = (($urandom % 3) == 0) ? 32'd0 : 32'($urandom % MEM_DEPTH);
    rTop = 32'($urandom % MEM_DEPTH);
    #1;
    {eRd, eWr, ePu, ePo, eRu, eRo, eAl} = '0;
    eAddr = '0;
    iw = mUse ? mHold : memRdata;
    tgt = {3'b000, iw[28:0]};
    tag = "R1";
    case (mPhase)
      0: begin
        eRd = 1; eAddr = 0; mPc = 1; mPhase = 1; mUse = 0;
      end
      1: begin
        mUse = 0;
        case (iw[31:29])
          3'd1: begin
            tag = "R3"; eRd = 1; ePo = 1; eAddr = pTop; mPhase = 2;
          end
          3'd2: begin
            tag = "R4"; eRd = 1; ePo = 1; eAddr = mPc; mSt = pTop;
            mPc = mPc + 1; mPhase = 3;
          end
          3'd3: begin
            tag = "R5"; eRd = 1; eRu = 1; eAddr = tgt;
            check("R5 return address", rPushData, mPc);
            mPc = tgt + 1;
          end
          3'd4: begin
            tag = "R6"; eRd = 1; eRo = 1; eAddr = rTop; mPc = rTop + 1;
          end
          3'd5: begin
            tag = "R7"; eRd = 1; ePo = 1;
            eAddr = (pTop == 0) ? tgt : mPc;
            mPc = eAddr + 1;
          end
          default: begin
            tag = "R2"; eRd = 1; eAl = 1; eAddr = mPc;
            check("R2 aluWord", {3'b000, aluWord}, tgt);
            mPc = mPc + 1;
          end
        endcase
      end
      2: begin
        tag = "R3"; eRd = 1; ePu = 1; eAddr = mPc; mPc = mPc + 1; mPhase = 1;
        check("R3 pushed data", pPushData, memRdata);
      end
      default: begin
        tag = "R4"; eWr = 1; ePo = 1; eAddr = mSt;
        mHold = memRdata; mUse = 1; mPhase = 1;
        check("R4 store data", memWdata, pTop);
      end
    endcase
    eStb = {25'd0, eRd, eWr, ePu, ePo, eRu, eRo, eAl};
    check({tag, " strobes"}, strobes(), eStb);
    check({tag, " address"}, memAddr, eAddr);
    if (memRd && memWr) begin
      fails++;
      $display("FAIL R8 read and write together act=11 exp=0x");
    end
    if (rPush && rPop) begin
      fails++;
      $display("FAIL R8 return push and pop together act=11 exp=0x");
    end
    if (memRd) rdNext = mem[memAddr % MEM_DEPTH];
    if (memWr) mem[memAddr % MEM_DEPTH] = memWdata;
  endtask

  task automatic loadProgram(int prog);
    for (int i = 0; i < MEM_DEPTH; i++) mem[i] = randWord();
    if (prog == 0) begin
      // nested calls with stores placed right before returns and calls
      mem[0]  = makeWord(3, 8);
      mem[1]  = makeWord(2, 0);
      mem[2]  = makeWord(3, 20);
      mem[3]  = makeWord(1, 0);
      mem[4]  = makeWord(5, 0);
      mem[8]  = makeWord(3, 12);
      mem[9]  = makeWord(1, 0);
      mem[10] = makeWord(2, 0);
      mem[11] = makeWord(4, 0);
      mem[12] = makeWord(0, 5);
      mem[13] = makeWord(2, 0);
      mem[14] = makeWord(4, 0);
      mem[20] = makeWord(2, 0);
      mem[21] = makeWord(4, 0);
    end
  endtask

  task automatic resetAndRun(int prog);
    loadProgram(prog);
    @(negedge clk);
    rstN = 0;
    #1;
    check("R1 strobes in reset", strobes(), 32'd0);
    @(negedge clk);
    #1;
    check("R1 strobes in reset", strobes(), 32'd0);
    @(negedge clk);
    rstN = 1;
    mPhase = 0;
    mUse = 0;
    evalCycle();
    for (int c = 0; c < RUN_CYCLES; c++) begin
      @(negedge clk);
      evalCycle();
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    mPhase = 0; mPc = 0; mSt = 0; mHold = 0; mUse = 0;
    for (int p = 0; p < PROGRAMS; p++) resetAndRun(p);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule